// File: doc/BRIEF.md
# Cascadable Prescaled Timer Bank

A bank of up-counting timers sits behind a small register port. Every timer has a live count, a reload latch and an 8-bit control byte. A running timer advances on one of two kinds of count event. The first is a tick from its own prescaler, which divides the system clock by 1, 64, 256 or 1024. The second, for every timer except the lowest, is the overflow of the timer one index below it. The second kind lets adjacent timers form 32-, 48- or 64-bit counters.

When a timer wraps past its all-ones value, it loads its reload latch and gives a one-cycle overflow pulse. If its interrupt enable bit is set, it also gives a one-cycle interrupt pulse. Software sets the reload value through the value address. Reading the same address returns the live count. Starting a timer copies the reload value into the counter and restarts the prescaler from phase zero.

The address is formed as `{timer index, select}`. Select 0 is the value word and select 1 is the control byte. Reads are combinational from the address.

Top module: `cascade_timer_bank`

## Requirements
- R1: After reset, every count, reload latch and control byte reads as zero, and the overflow and interrupt outputs are low.
- R2: A write to a value address (select 0) changes only the reload latch. A read of that address returns the live count, and a running count is not disturbed by the write.
- R3: Control bits [1:0] set the prescaler rate. The codes 00, 01, 10 and 11 advance a running, non-chained timer once every 1, 64, 256 and 1024 clock cycles.
- R4: With control bit 2 set, a timer above index 0 advances once for every overflow of the timer one index below it, in the same clock edge, and its rate field is ignored.
- R5: While control bit 7 is clear, the count holds its value.
- R6: A control write that changes bit 7 from 0 to 1 loads the count from the reload latch and clears the prescaler phase. The first increment then comes one full prescaler period after that write.
- R7: On the edge where a running timer at 0xFFFF takes a count event, it loads the reload latch and drives its overflow output high for exactly the following cycle. Back-to-back overflows are possible when the reload is 0xFFFF.
- R8: The interrupt output of a timer pulses together with its overflow pulse only when control bit 6 is set. Otherwise it stays low.
- R9: Control bit 2 has no effect on timer 0, which always counts from its prescaler.
- R10: A read of a control address (select 1) returns the stored control byte in bits [7:0] and zeros above.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| addr | input | 3 | {timer index, select}; select 0 is value, select 1 is control |
| wrData | input | 16 | Write data |
| rdData | output | 16 | Combinational read data for `addr` |
| ovfPulse | output | 4 | One-cycle overflow pulse per timer |
| irqPulse | output | 4 | One-cycle interrupt request per timer |

## Verification
The hardest case to reach is a chained timer advancing. It needs the lower timer started after the upper one is already armed. It also needs the lower timer's reload set close to 0xFFFF, so that several overflows happen within a short window. The stimulus arms timer 1 in chained mode with its slowest rate code, which must then be ignored. It then starts timer 0 at 0xFFFC and counts edges exactly, so that the upper count equals the number of lower wraps. The prescaler phase reset is brought out by stopping a divide-by-64 timer partway through a period, restarting it, and sampling one edge before and one edge after the first expected increment.

// File: rtl/tct_pkg.sv
package tct_pkg;

  // control byte bit positions (decoded by the timer logic)
  localparam int CTL_RUN   = 7;
  localparam int CTL_IRQ   = 6;
  localparam int CTL_CHAIN = 2;

  // largest prescaler shift, sizes the phase counter
  localparam int MAX_SHIFT = 10;

  typedef struct packed {
    logic       start;  // run bit rising this cycle
    logic       run;    // timer running
    logic       chain;  // count on lower overflow
    logic       irqEn;  // interrupt qualifier
    logic [1:0] rate;   // prescaler code
  } tctCtl_t;

  function automatic int unsigned rateShift(input logic [1:0] code);
    case (code)
      2'd0:    rateShift = 0;
      2'd1:    rateShift = 6;
      2'd2:    rateShift = 8;
      default: rateShift = MAX_SHIFT;
    endcase
  endfunction

endpackage

// File: rtl/tct_prescaler.sv
module tct_prescaler
  import tct_pkg::*;
#(
  parameter int PW = MAX_SHIFT
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       clear,
  input  logic       run,
  input  logic [1:0] rate,
  output logic       tick
);

  logic [PW-1:0] phaseQ;
  logic [PW-1:0] limit;

  always_comb begin
    limit = PW'((32'd1 << rateShift(rate)) - 32'd1);
    tick  = run && (phaseQ == limit);
  end

  always_ff @(posedge clk) begin
    if (!rstN || clear) begin
      phaseQ <= '0;
    end else if (run) begin
      phaseQ <= tick ? '0 : phaseQ + PW'(1);
    end
  end

endmodule

// File: rtl/tct_ctrl.sv
module tct_ctrl
  import tct_pkg::*;
#(
  parameter int NT     = 4,
  parameter int CNT_W  = 16,
  parameter int ADDR_W = $clog2(NT) + 1
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       wrEn,
  input  logic [ADDR_W-1:0]          addr,
  input  logic [CNT_W-1:0]           wrData,
  input  logic [NT-1:0][CNT_W-1:0]   liveCnt,
  output tctCtl_t [NT-1:0]           ctl,
  output logic [NT-1:0][CNT_W-1:0]   reload,
  output logic [CNT_W-1:0]           rdData
);

  localparam int IDX_W = ADDR_W - 1;

  logic [IDX_W-1:0] idx;
  logic             selCtl;
  logic [NT-1:0][7:0] ctrlQ;

  assign idx    = addr[ADDR_W-1:1];
  assign selCtl = addr[0];

  for (genvar i = 0; i < NT; i++) begin : g_reg
    logic hitCtl, hitVal;
    assign hitCtl = wrEn && selCtl  && (idx == IDX_W'(i));
    assign hitVal = wrEn && !selCtl && (idx == IDX_W'(i));

    always_ff @(posedge clk) begin
      if (!rstN) begin
        ctrlQ[i]  <= '0;
        reload[i] <= '0;
      end else begin
        if (hitCtl) ctrlQ[i]  <= wrData[7:0];
        if (hitVal) reload[i] <= wrData;
      end
    end

    assign ctl[i].start = hitCtl && wrData[CTL_RUN] && !ctrlQ[i][CTL_RUN];
    assign ctl[i].run   = ctrlQ[i][CTL_RUN];
    assign ctl[i].irqEn = ctrlQ[i][CTL_IRQ];
    assign ctl[i].rate  = ctrlQ[i][1:0];
    if (i == 0) begin : g_base
      assign ctl[i].chain = 1'b0;
    end else begin : g_upper
      assign ctl[i].chain = ctrlQ[i][CTL_CHAIN];
    end
  end

  always_comb begin
    rdData = '0;
    for (int k = 0; k < NT; k++) begin
      if (idx == IDX_W'(k)) begin
        rdData = selCtl ? CNT_W'(ctrlQ[k]) : liveCnt[k];
      end
    end
  end

endmodule

// File: rtl/tct_datapath.sv
module tct_datapath
  import tct_pkg::*;
#(
  parameter int NT    = 4,
  parameter int CNT_W = 16
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  tctCtl_t [NT-1:0]         ctl,
  input  logic [NT-1:0][CNT_W-1:0] reload,
  output logic [NT-1:0][CNT_W-1:0] cnt,
  output logic [NT-1:0]            ovfQ,
  output logic [NT-1:0]            irqQ
);

  logic ovfC [NT];
  logic evt  [NT];
  logic presTick [NT];

  for (genvar i = 0; i < NT; i++) begin : g_tmr
    logic atMax;

    tct_prescaler #(.PW(MAX_SHIFT)) u_pres (
      .clk   (clk),
      .rstN  (rstN),
      .clear (ctl[i].start),
      .run   (ctl[i].run && !ctl[i].start),
      .rate  (ctl[i].rate),
      .tick  (presTick[i])
    );

    if (i == 0) begin : g_src0
      assign evt[i] = presTick[i];
    end else begin : g_srcN
      assign evt[i] = ctl[i].chain ? ovfC[i-1] : presTick[i];
    end

    assign atMax   = &cnt[i];
    assign ovfC[i] = ctl[i].run && !ctl[i].start && evt[i] && atMax;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        cnt[i]  <= '0;
        ovfQ[i] <= 1'b0;
        irqQ[i] <= 1'b0;
      end else begin
        if (ctl[i].start) begin
          cnt[i] <= reload[i];
        end else if (ctl[i].run && evt[i]) begin
          cnt[i] <= atMax ? reload[i] : cnt[i] + CNT_W'(1);
        end
        ovfQ[i] <= ovfC[i];
        irqQ[i] <= ovfC[i] && ctl[i].irqEn;
      end
    end
  end

endmodule

// File: rtl/cascade_timer_bank.sv
module cascade_timer_bank
  import tct_pkg::*;
#(
  parameter  int NUM_TIMERS = 4,
  parameter  int CNT_W      = 16,
  localparam int ADDR_W     = $clog2(NUM_TIMERS) + 1
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  wrEn,
  input  logic [ADDR_W-1:0]     addr,
  input  logic [CNT_W-1:0]      wrData,
  output logic [CNT_W-1:0]      rdData,
  output logic [NUM_TIMERS-1:0] ovfPulse,
  output logic [NUM_TIMERS-1:0] irqPulse
);

  tctCtl_t [NUM_TIMERS-1:0]         ctl;
  logic [NUM_TIMERS-1:0][CNT_W-1:0] reload;
  logic [NUM_TIMERS-1:0][CNT_W-1:0] liveCnt;
  logic [NUM_TIMERS-1:0]            startAll, runAll, irqEnAll;

  for (genvar i = 0; i < NUM_TIMERS; i++) begin : g_flat
    assign startAll[i] = ctl[i].start;
    assign runAll[i]   = ctl[i].run;
    assign irqEnAll[i] = ctl[i].irqEn;
  end

  tct_ctrl #(.NT(NUM_TIMERS), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .wrEn    (wrEn),
    .addr    (addr),
    .wrData  (wrData),
    .liveCnt (liveCnt),
    .ctl     (ctl),
    .reload  (reload),
    .rdData  (rdData)
  );

  tct_datapath #(.NT(NUM_TIMERS), .CNT_W(CNT_W)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .ctl    (ctl),
    .reload (reload),
    .cnt    (liveCnt),
    .ovfQ   (ovfPulse),
    .irqQ   (irqPulse)
  );

endmodule

// File: rtl/tct_checker.sv
module tct_checker #(
  parameter int NT    = 4,
  parameter int CNT_W = 16
) (
  input logic                     clk,
  input logic                     rstN,
  input logic [NT-1:0][CNT_W-1:0] liveCnt,
  input logic [NT-1:0][CNT_W-1:0] reload,
  input logic [NT-1:0]            startAll,
  input logic [NT-1:0]            runAll,
  input logic [NT-1:0]            irqEnAll,
  input logic [NT-1:0]            ovfPulse,
  input logic [NT-1:0]            irqPulse
);

  for (genvar i = 0; i < NT; i++) begin : g_chk
    AST_HOLD_WHEN_STOPPED: assert property (@(posedge clk) disable iff (!rstN)
      (!runAll[i] && !startAll[i]) |=> (liveCnt[i] == $past(liveCnt[i]))); // R5

    AST_START_LOADS: assert property (@(posedge clk) disable iff (!rstN)
      startAll[i] |=> (liveCnt[i] == $past(reload[i]))); // R6

    AST_OVF_RELOADS: assert property (@(posedge clk) disable iff (!rstN)
      ovfPulse[i] |-> (liveCnt[i] == $past(reload[i]))); // R7

    AST_STEP_BY_ONE: assert property (@(posedge clk) disable iff (!rstN)
      (runAll[i] && !startAll[i]) |=> (liveCnt[i] == $past(liveCnt[i]) ||
        liveCnt[i] == $past(liveCnt[i]) + CNT_W'(1) || ovfPulse[i])); // R3

    AST_IRQ_WITH_OVF: assert property (@(posedge clk) disable iff (!rstN)
      irqPulse[i] |-> ovfPulse[i]); // R8

    AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rstN)
      irqPulse[i] |-> $past(irqEnAll[i])); // R8
  end

endmodule

bind cascade_timer_bank tct_checker #(.NT(NUM_TIMERS), .CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .liveCnt  (liveCnt),
  .reload   (reload),
  .startAll (startAll),
  .runAll   (runAll),
  .irqEnAll (irqEnAll),
  .ovfPulse (ovfPulse),
  .irqPulse (irqPulse)
);

// File: tb/cascade_timer_bank_bench.sv
module cascade_timer_bank_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [2:0]  addr = '0;
  logic [15:0] wrData = '0;
  logic [15:0] rdData;
  logic [3:0]  ovfPulse, irqPulse;

  int nChecks = 0;
  int nFails  = 0;
  int ovfSeen [4];
  int irqSeen [4];
  bit done = 0;

  always #10 clk = ~clk;

  cascade_timer_bank u_cascade_timer_bank (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .ovfPulse(ovfPulse), .irqPulse(irqPulse)
  );

  always @(negedge clk) begin
    for (int k = 0; k < 4; k++) begin
      if (ovfPulse[k]) ovfSeen[k]++;
      if (irqPulse[k]) irqSeen[k]++;
    end
  end

  typedef struct packed {
    logic [1:0]  tmr;
    logic [7:0]  ctrl;
    logic [15:0] rl;
    logic [15:0] edges;
    logic [15:0] expCnt;
    logic [7:0]  expOvf;
    logic [7:0]  expIrq;
  } vec_t;

  // R3 rates, R7 wrap and reload, R8 interrupt qualification
  localparam vec_t VECS [7] = '{
    '{2'd0, 8'h80, 16'h0000, 16'd10,   16'h000A, 8'd0, 8'd0},
    '{2'd1, 8'h81, 16'h0100, 16'd200,  16'h0103, 8'd0, 8'd0},
    '{2'd2, 8'h82, 16'h0000, 16'd600,  16'h0002, 8'd0, 8'd0},
    '{2'd3, 8'h83, 16'h0010, 16'd2100, 16'h0012, 8'd0, 8'd0},
    '{2'd0, 8'hC0, 16'hFFF0, 16'd40,   16'hFFF8, 8'd2, 8'd2},
    '{2'd1, 8'h80, 16'hFFFE, 16'd5,    16'hFFFF, 8'd2, 8'd0},
    '{2'd2, 8'h80, 16'hFFFF, 16'd3,    16'hFFFF, 8'd3, 8'd0}
  };

  task automatic check(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] t, input logic sel, input logic [15:0] d);
    @(negedge clk);
    wrEn = 1'b1; addr = {t, sel}; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input logic [1:0] t, input logic sel, output logic [15:0] d);
    addr = {t, sel};
    #1 d = rdData;
  endtask

  task automatic stopAll();
    for (int k = 0; k < 4; k++) wr(2'(k), 1'b1, 16'h0000);
    #1;
    for (int k = 0; k < 4; k++) begin ovfSeen[k] = 0; irqSeen[k] = 0; end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    logic [15:0] v, w;
    for (int k = 0; k < 4; k++) begin ovfSeen[k] = 0; irqSeen[k] = 0; end
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 / R10: reset state through the read port
    for (int k = 0; k < 4; k++) begin
      rd(2'(k), 1'b0, v); check("R1 count", v, 0);
      rd(2'(k), 1'b1, v); check("R1 R10 control", v, 0);
    end
    check("R1 outputs", {ovfPulse, irqPulse}, 0);

    // vector table
    for (int n = 0; n < 7; n++) begin
      vec_t vc = VECS[n];
      stopAll();
      wr(vc.tmr, 1'b0, vc.rl);
      wr(vc.tmr, 1'b1, {8'h00, vc.ctrl});
      repeat (int'(vc.edges)) @(negedge clk);
      rd(vc.tmr, 1'b0, v);
      check($sformatf("R3/R7 vector %0d count", n), v, vc.expCnt);
      check($sformatf("R7 vector %0d overflows", n), ovfSeen[vc.tmr], vc.expOvf);
      check($sformatf("R8 vector %0d interrupts", n), irqSeen[vc.tmr], vc.expIrq);
    end

    // R2 / R6 / R5 on timer 0
    stopAll();
    wr(2'd0, 1'b0, 16'h0000);
    wr(2'd0, 1'b1, 16'h0080);
    repeat (4) @(negedge clk);
    rd(2'd0, 1'b0, v); check("R3 div1 count", v, 16'h0004);
    wr(2'd0, 1'b0, 16'h5555);
    rd(2'd0, 1'b0, v); check("R2 live count kept", v, 16'h0006);
    wr(2'd0, 1'b1, 16'h0000);
    wr(2'd0, 1'b1, 16'h0080);
    rd(2'd0, 1'b0, v); check("R6 start loads latch", v, 16'h5555);
    wr(2'd0, 1'b1, 16'h0000);
    rd(2'd0, 1'b0, v); check("R5 stop value", v, 16'h5557);
    repeat (20) @(negedge clk);
    rd(2'd0, 1'b0, w); check("R5 hold", w, 16'h5557);

    // R6 prescaler phase cleared on restart
    stopAll();
    wr(2'd1, 1'b0, 16'h0000);
    wr(2'd1, 1'b1, 16'h0081);
    repeat (40) @(negedge clk);
    wr(2'd1, 1'b1, 16'h0001);
    wr(2'd1, 1'b1, 16'h0081);
    repeat (63) @(negedge clk);
    rd(2'd1, 1'b0, v); check("R6 phase before period", v, 16'h0000);
    @(negedge clk);
    rd(2'd1, 1'b0, v); check("R6 phase at period", v, 16'h0001);

    // R4 chained timer 1 fed by timer 0, rate code 11 ignored
    stopAll();
    wr(2'd0, 1'b0, 16'hFFFC);
    wr(2'd1, 1'b0, 16'h0000);
    wr(2'd1, 1'b1, 16'h00C7);
    wr(2'd0, 1'b1, 16'h0080);
    repeat (20) @(negedge clk);
    rd(2'd1, 1'b0, v); check("R4 chained count", v, 16'h0005);
    rd(2'd0, 1'b0, v); check("R4 lower reloaded", v, 16'hFFFC);
    check("R8 chained no irq", irqSeen[1], 0);

    // R9 chain bit on timer 0
    stopAll();
    wr(2'd0, 1'b0, 16'h0000);
    wr(2'd0, 1'b1, 16'h0084);
    repeat (10) @(negedge clk);
    rd(2'd0, 1'b0, v); check("R9 timer0 ignores chain", v, 16'h000A);

    // R10 control readback
    stopAll();
    wr(2'd3, 1'b1, 16'h0065);
    rd(2'd3, 1'b1, v); check("R10 control readback", v, 16'h0065);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule